// File: doc/BRIEF.md
# Vectored Interrupt Controller with Countdown Timer

This block is the interrupt unit that sits beside a small processor core. It watches a vector of external interrupt lines, holds a software-visible mask and a set of pending flags, and asks the core to enter a single handler whenever an unmasked line is pending and no handler is running. Line 0 is fed by a built-in countdown timer. Line 1 is raised by breakpoint, environment-call and illegal-instruction events. Line 2 is raised by misaligned bus accesses. Two per-line parameters decide whether a line is blocked for good, and whether it is latched (a one-cycle pulse stays pending until handler entry) or level sensitive.

Handler entry uses a request/acknowledge pair. The core raises `enter_ack` in the cycle it takes the jump to `enter_pc` and supplies the interrupted return address on `ret_addr_in`. In that cycle the unit stores the address, records every dispatched line as one bitmask, and drives those lines' end-of-interrupt outputs until the core issues a return command. The core talks to the unit through a command port. A command is offered with `cmd_valid` and held, with `cmd_op` and `cmd_arg` stable, until `cmd_ready` is high. The transfer happens in the cycle where both are high, and `rsp_data` carries the result in that same cycle. Only the wait command applies back-pressure. All other commands are accepted at once.

Top module: `intc_vec`

## Requirements
- R1: A line whose bit is set in the `DIS_LINES` parameter never becomes pending, never raises `enter_req` and never appears in `eoi` or `svc_mask`.
- R2: A line whose bit is set in `PULSE_LINES` stays pending after a one-cycle high until it is dispatched. A line whose bit is clear is pending only in the cycle after it was sampled high.
- R3: After reset the mask is all ones, no line is pending, the timer is zero, `enter_req`, `eoi`, `svc_mask` and `halt` are all zero.
- R4: Command op 1 (mask write) loads `cmd_arg` into the mask, where bit i set masks line i. `rsp_data` returns the previous mask.
- R5: `enter_req` is high exactly when no handler is active, `halt` is low, and some pending line is neither masked nor disabled. `enter_pc` equals the `ENTRY_ADDR` parameter.
- R6: In a cycle with `enter_req` and `enter_ack` both high, the dispatched set (pending, not masked) goes to `svc_mask` and to `eoi`, from the next cycle. `ret_addr_in` is stored, and the dispatched pending bits are cleared. `eoi` holds until a return command.
- R7: Command op 3 (return) gives the stored return address on `rsp_data` and clears `eoi` from the next cycle, so dispatch can resume.
- R8: Command op 2 (timer load) loads `cmd_arg` into the timer and returns its old value. A nonzero timer decrements once per clock. A step from 1 to 0 makes line 0 pending. A timer of zero stays idle.
- R9: A `trap_break` pulse while line 1 is masked, or a `trap_misalign` pulse while line 2 is masked, sets `halt`. `halt` stays set until reset and blocks `enter_req`.
- R10: Command op 4 (wait) holds `cmd_ready` low while no line is pending. Once any line is pending, it is accepted and returns the pending bitmask.
- R11: Ops 0, 1, 2, 3, 5, 6 and 7 are accepted in the cycle they are offered. Ops 0, 5, 6 and 7 return zero and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | N | External interrupt lines |
| trap_break | input | 1 | Breakpoint, environment-call or illegal-instruction event (line 1) |
| trap_misalign | input | 1 | Misaligned bus access event (line 2) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | W | Command operand |
| rsp_data | output | W | Command result, valid in the transfer cycle |
| enter_req | output | 1 | Request to enter the handler |
| enter_ack | input | 1 | Core takes the handler entry this cycle |
| enter_pc | output | W | Handler entry address |
| ret_addr_in | input | W | Interrupted return address, sampled on entry |
| eoi | output | N | End-of-interrupt flags of the serviced lines |
| svc_mask | output | N | Bitmask of the lines serviced by the latest entry |
| halt | output | 1 | Core must stop |

## Verification
The hardest state to reach is the interaction between entry, new arrivals and return. A latched line must pulse again while its own handler is running, so that it is pending but held back, and it must then re-dispatch in the cycle after the return. A level line must drop before the core acknowledges, so the request goes away without a dispatch. The stimulus gets there by holding `enter_ack` low for chosen cycles, pulsing lines during an active handler, and reaching the timer's 1-to-0 step through a short reload. A behavioural model in the bench follows every cycle and compares all outputs.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_MASK  = 3'd1,
    OP_TIMER = 3'd2,
    OP_RET   = 3'd3,
    OP_WAIT  = 3'd4
  } intc_op_e;

  localparam int TIMER_LINE = 0;
  localparam int BREAK_LINE = 1;
  localparam int ALIGN_LINE = 2;
endpackage

// File: rtl/intc_timer.sv
module intc_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         fire
);
  localparam logic [W-1:0] ONE = W'(1);

  // R8: fires on the 1 -> 0 step unless a reload replaces it
  assign fire = (count == ONE) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (count != '0)    count <= count - ONE;
  end
endmodule

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int           N     = 32,
  parameter logic [N-1:0] PULSE = '1,
  parameter logic [N-1:0] DIS   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic q;
    if (DIS[i]) begin : g_off
      // R1: blocked line never pends
      assign q = 1'b0;
    end else if (PULSE[i]) begin : g_latch
      // R2: held until dispatch
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q | raw[i]) & ~clr[i];
      end
    end else begin : g_level
      // R2: follows the sampled level
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= raw[i] & ~clr[i];
      end
    end
    assign pend[i] = q;
  end
endmodule

// File: rtl/intc_vec.sv
module intc_vec
  import intc_pkg::*;
#(
  parameter int           N           = 32,
  parameter int           W           = 32,
  parameter logic [N-1:0] DIS_LINES   = '0,
  parameter logic [N-1:0] PULSE_LINES = '1,
  parameter logic [W-1:0] ENTRY_ADDR  = W'(16)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_lines,
  input  logic         trap_break,
  input  logic         trap_misalign,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_arg,
  output logic [W-1:0] rsp_data,
  output logic         enter_req,
  input  logic         enter_ack,
  output logic [W-1:0] enter_pc,
  input  logic [W-1:0] ret_addr_in,
  output logic [N-1:0] eoi,
  output logic [N-1:0] svc_mask,
  output logic         halt
);
  logic [N-1:0] mask_q, pend, raw, clr, dmask, eff_mask;
  logic [W-1:0] ret_q, tmr_count;
  logic         tmr_fire, active, take, hs;
  logic         do_mask, do_tmr, do_ret;

  assign hs      = cmd_valid && cmd_ready;
  assign do_mask = hs && (cmd_op == OP_MASK);
  assign do_tmr  = hs && (cmd_op == OP_TIMER);
  assign do_ret  = hs && (cmd_op == OP_RET);

  intc_timer #(.W(W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(do_tmr), .load_val(cmd_arg),
    .count(tmr_count), .fire(tmr_fire)
  );

  always_comb begin
    raw = irq_lines;
    raw[TIMER_LINE] = irq_lines[TIMER_LINE] | tmr_fire;
    raw[BREAK_LINE] = irq_lines[BREAK_LINE] | trap_break;
    raw[ALIGN_LINE] = irq_lines[ALIGN_LINE] | trap_misalign;
  end

  intc_pend #(.N(N), .PULSE(PULSE_LINES), .DIS(DIS_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .raw(raw), .clr(clr), .pend(pend)
  );

  // R5: dispatch condition
  assign eff_mask  = mask_q | DIS_LINES;
  assign dmask     = pend & ~eff_mask;
  assign active    = |eoi;
  assign enter_req = !active && !halt && (|dmask);
  assign take      = enter_req && enter_ack;
  assign clr       = take ? dmask : '0;
  assign enter_pc  = ENTRY_ADDR;

  // R10 / R11: only the wait command back-pressures
  assign cmd_ready = (cmd_op == OP_WAIT) ? (|pend) : 1'b1;

  always_comb begin
    unique case (cmd_op)
      OP_MASK:  rsp_data = W'(mask_q);
      OP_TIMER: rsp_data = tmr_count;
      OP_RET:   rsp_data = ret_q;
      OP_WAIT:  rsp_data = W'(pend);
      default:  rsp_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '1;
      eoi      <= '0;
      svc_mask <= '0;
      ret_q    <= '0;
      halt     <= 1'b0;
    end else begin
      if (do_mask) mask_q <= cmd_arg[N-1:0];
      if (take) begin
        eoi      <= dmask;
        svc_mask <= dmask;
        ret_q    <= ret_addr_in;
      end else if (do_ret) begin
        eoi <= '0;
      end
      if ((trap_break && eff_mask[BREAK_LINE]) ||
          (trap_misalign && eff_mask[ALIGN_LINE]))
        halt <= 1'b1;
    end
  end
endmodule

// File: rtl/intc_vec_chk.sv
module intc_vec_chk
  import intc_pkg::*;
#(
  parameter int           N         = 32,
  parameter logic [N-1:0] DIS_LINES = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         cmd_ready,
  input logic [2:0]   cmd_op,
  input logic         enter_req,
  input logic         enter_ack,
  input logic [N-1:0] eoi,
  input logic [N-1:0] svc_mask,
  input logic         halt
);
  a_r1_disabled_never_served: assert property (@(posedge clk) disable iff (!rst_n)
    ((eoi & DISABLE_CHK) == '0) && ((svc_mask & DISABLE_CHK) == '0));
  localparam logic [N-1:0] DISABLE_CHK = DIS_LINES;

  a_r5_no_req_in_handler: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi != '0) |-> !enter_req);

  a_r6_eoi_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((eoi != '0) && !(cmd_valid && cmd_ready && cmd_op == OP_RET)) |=> $stable(eoi));

  a_r6_entry_sets_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && enter_ack) |=> (eoi != '0) && (eoi == svc_mask));

  a_r7_return_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == OP_RET && !(enter_req && enter_ack)) |=> (eoi == '0));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  a_r9_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !enter_req);

  a_r11_immediate_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != OP_WAIT) |-> cmd_ready);
endmodule

bind intc_vec intc_vec_chk #(.N(N), .DIS_LINES(DIS_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .enter_req(enter_req), .enter_ack(enter_ack),
  .eoi(eoi), .svc_mask(svc_mask), .halt(halt)
);

// File: tb/sim_intc_vec.sv
module sim_intc_vec;
  localparam bit [31:0] DIS   = 32'h8000_0000;
  localparam bit [31:0] PULSE = 32'hFFFF_FF0F;
  localparam bit [31:0] ENTRY = 32'h0000_0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic trap_break = 1'b0, trap_misalign = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [31:0] cmd_arg = '0, ret_addr_in = '0;
  logic enter_ack = 1'b0;
  logic cmd_ready, enter_req, halt;
  logic [31:0] rsp_data, enter_pc, eoi, svc_mask;

  always #5 clk = ~clk;

  intc_vec #(.N(32), .W(32), .DIS_LINES(DIS), .PULSE_LINES(PULSE), .ENTRY_ADDR(ENTRY)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .trap_break(trap_break),
    .trap_misalign(trap_misalign), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .rsp_data(rsp_data), .enter_req(enter_req),
    .enter_ack(enter_ack), .enter_pc(enter_pc), .ret_addr_in(ret_addr_in),
    .eoi(eoi), .svc_mask(svc_mask), .halt(halt)
  );

  int checks = 0, errors = 0;

  // reference state
  bit [31:0] m_mask, m_pend, m_eoi, m_svc, m_pc, m_tmr;
  bit m_halt;
  bit last_hs;

  task automatic expect_eq(input bit [31:0] act, input bit [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mask = '1; m_pend = '0; m_eoi = '0; m_svc = '0; m_pc = '0; m_tmr = '0; m_halt = 0;
  endtask

  // one clock: compare outputs, then advance the reference
  task automatic step();
    bit [31:0] raw, dm, n_pend, effm, exp_rsp;
    bit fire, req, rdy, hs, take;
    #2;
    effm = m_mask | DIS;
    dm = m_pend & ~effm;
    req = (m_eoi == 0) && !m_halt && (dm != 0);
    rdy = (cmd_op == 3'd4) ? (m_pend != 0) : 1'b1;
    hs = cmd_valid && rdy;
    case (cmd_op)
      3'd1: exp_rsp = m_mask;
      3'd2: exp_rsp = m_tmr;
      3'd3: exp_rsp = m_pc;
      3'd4: exp_rsp = m_pend;
      default: exp_rsp = 0;
    endcase
    expect_eq(32'(enter_req), 32'(req), "R5 enter_req");
    expect_eq(32'(cmd_ready), 32'(rdy), "R10/R11 cmd_ready");
    expect_eq(eoi, m_eoi, "R6 eoi");
    expect_eq(svc_mask, m_svc, "R6 svc_mask");
    expect_eq(32'(halt), 32'(m_halt), "R9 halt");
    if (hs) expect_eq(rsp_data, exp_rsp, "R4/R7/R8/R10 rsp_data");
    last_hs = hs;
    fire = (m_tmr == 1) && !(hs && cmd_op == 3'd2);
    raw = irq_lines;
    if (fire) raw[0] = 1'b1;
    if (trap_break) raw[1] = 1'b1;
    if (trap_misalign) raw[2] = 1'b1;
    take = req && enter_ack;
    for (int i = 0; i < 32; i++) begin
      if (DIS[i]) n_pend[i] = 1'b0;
      else if (PULSE[i]) n_pend[i] = m_pend[i] | raw[i];
      else n_pend[i] = raw[i];
      if (take && dm[i]) n_pend[i] = 1'b0;
    end
    @(posedge clk);
    if ((trap_break && effm[1]) || (trap_misalign && effm[2])) m_halt = 1;
    if (hs && cmd_op == 3'd2) m_tmr = cmd_arg;
    else if (m_tmr != 0) m_tmr = m_tmr - 1;
    if (hs && cmd_op == 3'd1) m_mask = cmd_arg;
    if (take) begin m_eoi = dm; m_svc = dm; m_pc = ret_addr_in; end
    else if (hs && cmd_op == 3'd3) m_eoi = '0;
    m_pend = n_pend;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_cmd(input bit [2:0] op, input bit [31:0] arg);
    cmd_valid = 1; cmd_op = op; cmd_arg = arg;
    for (int i = 0; i < 50; i++) begin
      step();
      if (last_hs) break;
    end
    cmd_valid = 0; cmd_op = 3'd0; cmd_arg = '0;
  endtask

  task automatic pulse_line(input int ln);
    irq_lines[ln] = 1'b1; step(); irq_lines[ln] = 1'b0;
  endtask

  task automatic enter(input bit [31:0] pc);
    ret_addr_in = pc; enter_ack = 1; step(); enter_ack = 0; ret_addr_in = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R3 reset state and R5 entry address
    idle(2);
    expect_eq(enter_pc, ENTRY, "R5 enter_pc");
    expect_eq(32'(enter_req), 0, "R3 no request after reset");
    do_cmd(3'd2, 0);                       // R8 timer old value 0 (R3)
    do_cmd(3'd1, 32'hFFFF_FEEF);           // R4 old mask all ones; unmask lines 4, 8
    // R2 latched line: pulse, delayed acknowledge
    pulse_line(8);
    idle(2);
    enter(32'h0000_1234);
    expect_eq(eoi, 32'h100, "R6 eoi after entry");
    pulse_line(8);                         // pending while handler runs
    idle(2);
    expect_eq(32'(enter_req), 0, "R5 no request inside handler");
    do_cmd(3'd3, 0);                       // R7 returns 0x1234
    expect_eq(32'(enter_req), 1, "R7 re-dispatch after return");
    enter(32'h0000_2000);
    do_cmd(3'd3, 0);
    // R2 level line dropped before acknowledge
    pulse_line(4);
    step();
    expect_eq(32'(enter_req), 0, "R2 level line gone");
    irq_lines[4] = 1; idle(2);
    enter(32'h0000_3000);
    idle(1);
    do_cmd(3'd3, 0);
    irq_lines[4] = 0; idle(2);
    // R1 disabled line with everything unmasked
    do_cmd(3'd1, 32'h0000_0000);
    pulse_line(31);
    idle(3);
    expect_eq(32'(enter_req), 0, "R1 disabled line ignored");
    // two latched lines in one entry
    irq_lines[9] = 1; irq_lines[8] = 1; step(); irq_lines = '0;
    enter(32'h0000_4000);
    expect_eq(svc_mask, 32'h300, "R6 joint bitmask");
    do_cmd(3'd3, 0);
    // R8 timer: only line 0 unmasked
    do_cmd(3'd1, 32'hFFFF_FFFE);
    do_cmd(3'd2, 32'd5);
    idle(6);
    expect_eq(32'(enter_req), 1, "R8 timer raised line 0");
    enter(32'h0000_5000);
    do_cmd(3'd3, 0);
    do_cmd(3'd2, 32'd9);
    idle(3);
    do_cmd(3'd2, 32'd0);                   // returns remaining count
    idle(12);
    do_cmd(3'd0, 32'hDEAD_BEEF);           // R11 no-op
    do_cmd(3'd6, 32'h1);
    // R10 wait command
    do_cmd(3'd1, 32'hFFFF_FFFF);
    cmd_valid = 1; cmd_op = 3'd4;
    idle(3);
    expect_eq(32'(cmd_ready), 0, "R10 wait stalls");
    irq_lines[12] = 1; step(); irq_lines[12] = 0;
    step();
    cmd_valid = 0; cmd_op = 3'd0;
    idle(1);
    // R9 trap paths
    do_cmd(3'd1, 32'hFFFF_FFFB);
    trap_misalign = 1; step(); trap_misalign = 0;
    expect_eq(32'(halt), 0, "R9 unmasked trap does not halt");
    enter(32'h0000_6000);
    do_cmd(3'd3, 0);
    trap_break = 1; step(); trap_break = 0;
    expect_eq(32'(halt), 1, "R9 masked trap halts");
    do_cmd(3'd1, 32'hFFFF_EFFF);           // line 12 pending and unmasked
    idle(3);
    expect_eq(32'(enter_req), 0, "R9 halt blocks dispatch");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule